// File: doc/BRIEF.md
# Machine-Mode Trap and Interrupt Unit

This block keeps the machine-level trap state of a small RISC-V hart: the pending and enable interrupt masks, the status fields that save and restore the interrupt enable and privilege, the cause, the exception PC, the trap value and the trap vector base. Four interrupt request lines come in: software, timer, external, and a debug-emulation request. The debug request cannot be masked. The block picks one interrupt by a fixed priority. It also accepts synchronous exception reports from the commit stage.

When an interrupt is taken, when an exception is accepted, or when an MRET retires, the block raises a redirect in the same cycle. It gives the fetch target and updates the CSRs and the privilege at the next clock edge. A plain CSR port lets the core read every register with no clock delay and write the writable fields. Standard machine CSR addresses are used: 0x300 status, 0x304 enable, 0x305 vector, 0x341 exception PC, 0x342 cause, 0x343 trap value, 0x344 pending.

Top module: `mtrap_unit`

## Requirements
- R1: After reset the privilege is machine (3), and status, exception PC, cause and trap value read 0. The vector reads RESET_TVEC (default 0), the enable register reads 0x4000, and no redirect is raised.
- R2: The pending register (0x344) reads the live request lines: software at bit 3, timer at bit 7, external at bit 11, debug at bit 14. Writes to it are ignored.
- R3: The enable register (0x304) stores only bits 3, 7 and 11. Bit 14 always reads 1 and every other bit always reads 0.
- R4: A debug request is taken in any privilege and under any enable setting. The cause becomes 0x8000000E (interrupt flag in the top bit, code 14).
- R5: Software, timer and external interrupts are taken only when their enable bit is set, the status MIE bit (bit 3) is set, and the privilege is machine.
- R6: Among interrupts that may be taken, debug (14) wins over external (11), external over software (3), and software over timer (7).
- R7: On trap entry the redirect is raised in the same cycle, with target vector & ~3. At the next edge the exception PC takes cmt_pc_i, status MPIE (bit 7) takes the old MIE, MIE clears, MPP (bits 12:11) takes the old privilege, and the privilege becomes machine.
- R8: An accepted exception writes its 4-bit code into the cause with the top bit clear. The trap value takes exc_fetch_addr_i for codes 1 (fetch access fault) and 12 (fetch page fault), and exc_tval_i for every other code.
- R9: When an interrupt is taken in the same cycle as an exception, the exception is dropped. The cause records the interrupt and the trap value is written 0.
- R10: On MRET with no trap in the cycle, the redirect target is the exception PC. At the next edge MIE takes MPIE, MPIE becomes 1, the privilege takes MPP, and MPP becomes user (0).
- R11: CSR writes take effect at the next edge. In status only bits 3, 7 and 12:11 are kept, and an MPP value other than 3 becomes 0. A trap or MRET in the same cycle discards the write.
- R12: Reads of addresses the block does not implement return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_ext_i | input | 1 | External interrupt request |
| irq_tmr_i | input | 1 | Timer interrupt request |
| irq_sw_i | input | 1 | Software interrupt request |
| irq_dbg_i | input | 1 | Debug-emulation interrupt request, unmaskable |
| exc_valid_i | input | 1 | Commit stage reports an exception |
| exc_cause_i | input | 4 | Exception code |
| cmt_pc_i | input | XLEN | PC of the instruction at commit |
| exc_tval_i | input | XLEN | Trap value from commit, 0 when none applies |
| exc_fetch_addr_i | input | XLEN | Faulting fetch address for fetch faults |
| mret_i | input | 1 | MRET retires this cycle |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data, combinational |
| redirect_valid_o | output | 1 | Fetch redirect this cycle |
| redirect_pc_o | output | XLEN | Redirect target |
| priv_o | output | 2 | Current privilege (3 machine, 0 user) |

## Verification
The bench raises a debug request while the global enable is clear, the enable mask is empty and the hart is in user mode. A design that honoured the masks for this source would never redirect. It reports fetch faults whose fetch address differs from the PC, so a trap value copied from the PC shows up at once. It fires an external interrupt and an exception in the same cycle, which catches a design that records the exception cause or leaves a stale trap value. It also puts a CSR write on the same cycle as a trap, which exposes a write that wrongly overrides the trap's exception PC. Finally, it returns to user mode with MRET and then offers an enabled external interrupt, which catches a design that takes maskable interrupts outside machine mode.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  localparam logic [11:0] CSR_MSTATUS = 12'h300;
  localparam logic [11:0] CSR_MIE     = 12'h304;
  localparam logic [11:0] CSR_MTVEC   = 12'h305;
  localparam logic [11:0] CSR_MEPC    = 12'h341;
  localparam logic [11:0] CSR_MCAUSE  = 12'h342;
  localparam logic [11:0] CSR_MTVAL   = 12'h343;
  localparam logic [11:0] CSR_MIP     = 12'h344;

  localparam int IRQ_SW  = 3;
  localparam int IRQ_TMR = 7;
  localparam int IRQ_EXT = 11;
  localparam int IRQ_DBG = 14;
  localparam int NIRQ    = 16;

  localparam logic [3:0] EXC_FETCH_ACCESS = 4'd1;
  localparam logic [3:0] EXC_FETCH_PAGE   = 4'd12;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam logic [NIRQ-1:0] MIE_WMASK = NIRQ'((1 << IRQ_SW) | (1 << IRQ_TMR) | (1 << IRQ_EXT));

  typedef struct packed {
    logic [1:0] mpp;
    logic       mpie;
    logic       mie;
  } mstat_t;

  function automatic logic [1:0] legal_priv(input logic [1:0] p);
    return (p == PRIV_M) ? PRIV_M : PRIV_U;
  endfunction

  function automatic logic [15:0] pack_mstatus(input mstat_t s);
    logic [15:0] w;
    w = '0;
    w[3]     = s.mie;
    w[7]     = s.mpie;
    w[12:11] = s.mpp;
    return w;
  endfunction

  function automatic mstat_t unpack_mstatus(input logic [15:0] w);
    mstat_t s;
    s.mie  = w[3];
    s.mpie = w[7];
    s.mpp  = legal_priv(w[12:11]);
    return s;
  endfunction

  function automatic logic is_fetch_fault(input logic [3:0] code);
    return (code == EXC_FETCH_ACCESS) || (code == EXC_FETCH_PAGE);
  endfunction
endpackage

// File: rtl/mtrap_irq_arb.sv
module mtrap_irq_arb
  import mtrap_pkg::*;
(
  input  logic [NIRQ-1:0] pend,
  input  logic [NIRQ-1:0] enab,
  output logic            take,
  output logic [3:0]      code
);
  localparam int NSRC = 4;
  // lowest priority first; the last hit in the loop wins
  localparam int ORDER [NSRC] = '{IRQ_TMR, IRQ_SW, IRQ_EXT, IRQ_DBG};

  logic [NIRQ-1:0] ready;
  assign ready = pend & enab;

  always_comb begin
    take = 1'b0;
    code = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (ready[ORDER[i]]) begin
        take = 1'b1;
        code = 4'(ORDER[i]);
      end
    end
  end
endmodule

// File: rtl/mtrap_csr_rmux.sv
module mtrap_csr_rmux
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [11:0]     addr,
  input  logic [15:0]     mstat_w,
  input  logic [15:0]     mie_w,
  input  logic [15:0]     mip_w,
  input  logic [XLEN-1:0] mtvec,
  input  logic [XLEN-1:0] mepc,
  input  logic [XLEN-1:0] mcause,
  input  logic [XLEN-1:0] mtval,
  output logic [XLEN-1:0] rdata
);
  always_comb begin
    unique case (addr)
      CSR_MSTATUS: rdata = XLEN'(mstat_w);
      CSR_MIE:     rdata = XLEN'(mie_w);
      CSR_MIP:     rdata = XLEN'(mip_w);
      CSR_MTVEC:   rdata = mtvec;
      CSR_MEPC:    rdata = mepc;
      CSR_MCAUSE:  rdata = mcause;
      CSR_MTVAL:   rdata = mtval;
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RESET_TVEC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_ext_i,
  input  logic            irq_tmr_i,
  input  logic            irq_sw_i,
  input  logic            irq_dbg_i,
  input  logic            exc_valid_i,
  input  logic [3:0]      exc_cause_i,
  input  logic [XLEN-1:0] cmt_pc_i,
  input  logic [XLEN-1:0] exc_tval_i,
  input  logic [XLEN-1:0] exc_fetch_addr_i,
  input  logic            mret_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            redirect_valid_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic [1:0]      priv_o
);
  localparam int CODE_PAD = XLEN - 1 - 4;

  mstat_t          mst_q;
  logic [1:0]      priv_q;
  logic [NIRQ-1:0] mie_q;
  logic [XLEN-1:0] mtvec_q, mepc_q, mcause_q, mtval_q;

  // named events, also observed by the checker
  logic [NIRQ-1:0] mip_w, mie_w, irq_en;
  logic            irq_take, exc_take, mret_take, trap_take, gate_m;
  logic [3:0]      irq_code;

  always_comb begin
    mip_w          = '0;
    mip_w[IRQ_SW]  = irq_sw_i;
    mip_w[IRQ_TMR] = irq_tmr_i;
    mip_w[IRQ_EXT] = irq_ext_i;
    mip_w[IRQ_DBG] = irq_dbg_i;
  end

  assign mie_w  = mie_q | (NIRQ'(1) << IRQ_DBG);
  assign gate_m = mst_q.mie && (priv_q == PRIV_M);

  always_comb begin
    irq_en          = mie_q & {NIRQ{gate_m}};
    irq_en[IRQ_DBG] = 1'b1;
  end

  mtrap_irq_arb u_arb (
    .pend (mip_w),
    .enab (irq_en),
    .take (irq_take),
    .code (irq_code)
  );

  assign exc_take  = exc_valid_i && !irq_take;
  assign trap_take = irq_take || exc_take;
  assign mret_take = mret_i && !trap_take;

  assign redirect_valid_o = trap_take || mret_take;
  assign redirect_pc_o    = trap_take ? {mtvec_q[XLEN-1:2], 2'b00} : mepc_q;
  assign priv_o           = priv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mst_q    <= '0;
      priv_q   <= PRIV_M;
      mie_q    <= '0;
      mtvec_q  <= RESET_TVEC;
      mepc_q   <= '0;
      mcause_q <= '0;
      mtval_q  <= '0;
    end else if (trap_take) begin
      mepc_q    <= cmt_pc_i;
      mst_q.mpie <= mst_q.mie;
      mst_q.mie <= 1'b0;
      mst_q.mpp <= priv_q;
      priv_q    <= PRIV_M;
      if (irq_take) begin
        mcause_q <= {1'b1, {CODE_PAD{1'b0}}, irq_code};
        mtval_q  <= '0;
      end else begin
        mcause_q <= {1'b0, {CODE_PAD{1'b0}}, exc_cause_i};
        mtval_q  <= is_fetch_fault(exc_cause_i) ? exc_fetch_addr_i : exc_tval_i;
      end
    end else if (mret_take) begin
      mst_q.mie  <= mst_q.mpie;
      mst_q.mpie <= 1'b1;
      mst_q.mpp  <= PRIV_U;
      priv_q     <= mst_q.mpp;
    end else if (csr_we_i) begin
      unique case (csr_addr_i)
        CSR_MSTATUS: mst_q   <= unpack_mstatus(csr_wdata_i[15:0]);
        CSR_MIE:     mie_q   <= csr_wdata_i[NIRQ-1:0] & MIE_WMASK;
        CSR_MTVEC:   mtvec_q <= csr_wdata_i;
        CSR_MEPC:    mepc_q  <= csr_wdata_i;
        CSR_MCAUSE:  mcause_q <= csr_wdata_i;
        CSR_MTVAL:   mtval_q <= csr_wdata_i;
        default:     ;
      endcase
    end
  end

  mtrap_csr_rmux #(.XLEN(XLEN)) u_rmux (
    .addr    (csr_addr_i),
    .mstat_w (pack_mstatus(mst_q)),
    .mie_w   (mie_w),
    .mip_w   (mip_w),
    .mtvec   (mtvec_q),
    .mepc    (mepc_q),
    .mcause  (mcause_q),
    .mtval   (mtval_q),
    .rdata   (csr_rdata_o)
  );
endmodule

// File: rtl/mtrap_chk.sv
module mtrap_chk
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_dbg_i,
  input logic            exc_valid_i,
  input logic [3:0]      exc_cause_i,
  input logic [XLEN-1:0] exc_fetch_addr_i,
  input logic [11:0]     csr_addr_i,
  input logic [XLEN-1:0] csr_rdata_o,
  input logic            redirect_valid_o,
  input logic [1:0]      priv_o,
  input logic            irq_take,
  input logic [3:0]      irq_code,
  input logic            exc_take,
  input logic            mret_take,
  input mstat_t          mst_q,
  input logic [XLEN-1:0] mcause_q,
  input logic [XLEN-1:0] mtval_q
);
  a_r4_dbg_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
    irq_dbg_i |-> (irq_take && irq_code == 4'd14));

  a_r5_masked_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_code != 4'd14) |-> (mst_q.mie && priv_o == PRIV_M));

  a_r7_redirect_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take || exc_take) |-> redirect_valid_o);

  a_r7_entry_state: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take || exc_take) |=> (priv_o == PRIV_M && !mst_q.mie && mst_q.mpie == $past(mst_q.mie)));

  a_r8_fetch_fault_tval: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && (exc_cause_i == 4'd1 || exc_cause_i == 4'd12)) |=> (mtval_q == $past(exc_fetch_addr_i)));

  a_r9_irq_beats_exc: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && exc_valid_i) |=> (mcause_q[XLEN-1] && mtval_q == '0));

  a_r10_mret_restore: assert property (@(posedge clk) disable iff (!rst_n)
    mret_take |=> (priv_o == $past(mst_q.mpp) && mst_q.mpie && mst_q.mpp == PRIV_U));

  a_r3_dbg_enable_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr_i == CSR_MIE) |-> csr_rdata_o[14]);
endmodule

bind mtrap_unit mtrap_chk #(.XLEN(XLEN)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .irq_dbg_i        (irq_dbg_i),
  .exc_valid_i      (exc_valid_i),
  .exc_cause_i      (exc_cause_i),
  .exc_fetch_addr_i (exc_fetch_addr_i),
  .csr_addr_i       (csr_addr_i),
  .csr_rdata_o      (csr_rdata_o),
  .redirect_valid_o (redirect_valid_o),
  .priv_o           (priv_o),
  .irq_take         (irq_take),
  .irq_code         (irq_code),
  .exc_take         (exc_take),
  .mret_take        (mret_take),
  .mst_q            (mst_q),
  .mcause_q         (mcause_q),
  .mtval_q          (mtval_q)
);

// File: tb/tb_mtrap_unit.sv
module tb_mtrap_unit;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_ext_i = 0, irq_tmr_i = 0, irq_sw_i = 0, irq_dbg_i = 0;
  logic exc_valid_i = 0;
  logic [3:0] exc_cause_i = '0;
  logic [XLEN-1:0] cmt_pc_i = '0, exc_tval_i = '0, exc_fetch_addr_i = '0;
  logic mret_i = 0, csr_we_i = 0;
  logic [11:0] csr_addr_i = '0;
  logic [XLEN-1:0] csr_wdata_i = '0;
  logic [XLEN-1:0] csr_rdata_o, redirect_pc_o;
  logic redirect_valid_o;
  logic [1:0] priv_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mtrap_unit #(.XLEN(XLEN)) dut (.*);

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [XLEN-1:0] v);
    csr_addr_i = a;
    #1;
    v = csr_rdata_o;
  endtask

  task automatic wr(input logic [11:0] a, input logic [XLEN-1:0] d);
    csr_we_i = 1; csr_addr_i = a; csr_wdata_i = d;
    @(negedge clk);
    csr_we_i = 0;
  endtask

  task automatic quiet();
    irq_ext_i = 0; irq_tmr_i = 0; irq_sw_i = 0; irq_dbg_i = 0;
    exc_valid_i = 0; mret_i = 0; csr_we_i = 0;
  endtask

  task automatic t_reset();
    logic [XLEN-1:0] v;
    rd(12'h300, v); chk("R1 status", v, 0);
    rd(12'h304, v); chk("R1 enable", v, 32'h4000);
    rd(12'h305, v); chk("R1 vector", v, 0);
    rd(12'h341, v); chk("R1 epc", v, 0);
    rd(12'h342, v); chk("R1 cause", v, 0);
    rd(12'h343, v); chk("R1 tval", v, 0);
    chk("R1 priv", 32'(priv_o), 3);
    chk("R1 no redirect", 32'(redirect_valid_o), 0);
  endtask

  task automatic t_enable();
    logic [XLEN-1:0] v;
    wr(12'h304, 32'hFFFF_FFFF);
    rd(12'h304, v); chk("R3 enable all ones", v, 32'h4888);
    wr(12'h304, 32'h0);
    rd(12'h304, v); chk("R3 bit14 stays", v, 32'h4000);
  endtask

  task automatic t_pending();
    logic [XLEN-1:0] v;
    irq_sw_i = 1; irq_tmr_i = 1; irq_ext_i = 1;
    rd(12'h344, v); chk("R2 pending live", v, 32'h0888);
    chk("R5 no take while masked", 32'(redirect_valid_o), 0);
    wr(12'h344, 32'h0);
    rd(12'h344, v); chk("R2 pending write ignored", v, 32'h0888);
    quiet();
    rd(12'h344, v); chk("R2 pending clears", v, 0);
  endtask

  task automatic t_status_warl();
    logic [XLEN-1:0] v;
    wr(12'h300, 32'hFFFF_FFFF);
    rd(12'h300, v); chk("R11 status fields", v, 32'h1888);
    wr(12'h300, 32'h0000_1000);
    rd(12'h300, v); chk("R11 mpp legalised", v, 0);
    rd(12'h7C0, v); chk("R12 unimplemented", v, 0);
  endtask

  task automatic t_entry();
    logic [XLEN-1:0] v;
    wr(12'h305, 32'h0000_1003);
    wr(12'h304, 32'h0000_0800);
    irq_ext_i = 1; #1;
    chk("R5 global enable clear", 32'(redirect_valid_o), 0);
    quiet();
    wr(12'h304, 32'h0);
    wr(12'h300, 32'h8);
    irq_ext_i = 1; #1;
    chk("R5 enable bit clear", 32'(redirect_valid_o), 0);
    quiet();
    wr(12'h304, 32'h0000_0800);
    irq_ext_i = 1; cmt_pc_i = 32'h0000_0120; #1;
    chk("R7 redirect valid", 32'(redirect_valid_o), 1);
    chk("R7 redirect target", redirect_pc_o, 32'h0000_1000);
    @(negedge clk); quiet();
    rd(12'h342, v); chk("R7 cause ext", v, 32'h8000_000B);
    rd(12'h341, v); chk("R7 epc", v, 32'h0000_0120);
    rd(12'h300, v); chk("R7 status saved", v, 32'h1880);
    chk("R7 priv", 32'(priv_o), 3);
  endtask

  task automatic fire_irqs(input logic s, input logic t, input logic e, input logic d,
                           input logic [XLEN-1:0] exp, input string req);
    logic [XLEN-1:0] v;
    wr(12'h300, 32'h8);
    irq_sw_i = s; irq_tmr_i = t; irq_ext_i = e; irq_dbg_i = d;
    @(negedge clk); quiet();
    rd(12'h342, v); chk(req, v, exp);
  endtask

  task automatic t_priority();
    wr(12'h304, 32'h0000_0888);
    fire_irqs(0, 1, 0, 0, 32'h8000_0007, "R6 timer alone");
    fire_irqs(1, 1, 0, 0, 32'h8000_0003, "R6 sw over timer");
    fire_irqs(1, 1, 1, 0, 32'h8000_000B, "R6 ext over sw");
    fire_irqs(1, 1, 1, 1, 32'h8000_000E, "R6 dbg over ext");
  endtask

  task automatic t_exc();
    logic [XLEN-1:0] v;
    exc_valid_i = 1; exc_cause_i = 4'd1; cmt_pc_i = 32'h400;
    exc_fetch_addr_i = 32'h402; exc_tval_i = 32'h55; #1;
    chk("R7 exc redirect", redirect_pc_o, 32'h1000);
    @(negedge clk); quiet();
    rd(12'h343, v); chk("R8 access fault tval", v, 32'h402);
    rd(12'h342, v); chk("R8 access fault cause", v, 32'h1);
    exc_valid_i = 1; exc_cause_i = 4'd12; cmt_pc_i = 32'h500; exc_fetch_addr_i = 32'h7FF0;
    @(negedge clk); quiet();
    rd(12'h343, v); chk("R8 page fault tval", v, 32'h7FF0);
    exc_valid_i = 1; exc_cause_i = 4'd2; cmt_pc_i = 32'h600; exc_fetch_addr_i = 32'h999;
    csr_we_i = 1; csr_addr_i = 12'h341; csr_wdata_i = 32'hDEAD;
    @(negedge clk); quiet();
    rd(12'h343, v); chk("R8 other tval", v, 32'h55);
    rd(12'h341, v); chk("R11 write lost to trap", v, 32'h600);
  endtask

  task automatic t_irq_vs_exc();
    logic [XLEN-1:0] v;
    wr(12'h304, 32'h0000_0800);
    wr(12'h300, 32'h8);
    irq_ext_i = 1; exc_valid_i = 1; exc_cause_i = 4'd2;
    cmt_pc_i = 32'h700; exc_tval_i = 32'h77;
    @(negedge clk); quiet();
    rd(12'h342, v); chk("R9 cause is irq", v, 32'h8000_000B);
    rd(12'h343, v); chk("R9 tval zero", v, 0);
    rd(12'h341, v); chk("R9 epc", v, 32'h700);
  endtask

  task automatic t_mret_dbg();
    logic [XLEN-1:0] v;
    wr(12'h300, 32'h80);
    wr(12'h341, 32'h2000);
    mret_i = 1; #1;
    chk("R10 redirect valid", 32'(redirect_valid_o), 1);
    chk("R10 redirect target", redirect_pc_o, 32'h2000);
    @(negedge clk); quiet();
    chk("R10 priv user", 32'(priv_o), 0);
    rd(12'h300, v); chk("R10 status", v, 32'h88);
    irq_ext_i = 1; #1;
    chk("R5 no take in user", 32'(redirect_valid_o), 0);
    quiet();
    wr(12'h304, 32'h0);
    wr(12'h300, 32'h0);
    irq_dbg_i = 1; cmt_pc_i = 32'h2040;
    rd(12'h344, v); chk("R2 dbg pending bit", v, 32'h4000);
    chk("R4 dbg unmasked", 32'(redirect_valid_o), 1);
    @(negedge clk); quiet();
    rd(12'h342, v); chk("R4 dbg cause", v, 32'h8000_000E);
    chk("R4 back to machine", 32'(priv_o), 3);
    rd(12'h300, v); chk("R7 mpp user saved", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_enable();
    t_pending();
    t_status_warl();
    t_entry();
    t_priority();
    t_exc();
    t_irq_vs_exc();
    t_mret_dbg();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule